// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a 32-bit processor whose instructions are one word each and sit on word boundaries. In every cycle it looks at the instruction being executed and at the two register operands read for it. From these it chooses the address to fetch next.

The default is to step to the following word. A compare-and-branch instruction adds a signed word offset to the address of the following instruction. A region jump swaps in a new low 28 bits and keeps the top four bits of the following address. A register jump takes its target from the first operand. The call form of the region jump also returns the address of the following instruction, together with a write strobe meant for the return-address register, number 31.

Instruction memory and the register file sit outside the block. The fetch side reads the counter output directly. The link outputs go to the register file's write port.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `pc` becomes 0 on that edge, and `link_we` reads 0 for as long as reset is held.
- R2: When the instruction is not a control transfer, `pc` becomes `pc + 4` on the next edge. This holds for any opcode other than 2, 3, 4 and 5, and for opcode 0 with a funct other than 6'b001000. Bits [31:26] of the instruction are the opcode and bits [5:0] are the funct.
- R3: Opcode 4 branches when `rs_val == rt_val`. When taken, the next `pc` is `pc + 4 + (sign-extended instr[15:0] << 2)`. When not taken, it is `pc + 4`.
- R4: Opcode 5 branches when `rs_val != rt_val`, with the same target arithmetic as R3.
- R5: Opcode 2 loads `pc` with `{(pc+4)[31:28], instr[25:0], 2'b00}`.
- R6: Opcode 3 loads `pc` with the same target as R5. In the same cycle it raises `link_we` and drives `link_data = pc + 4`.
- R7: Opcode 0 with funct 6'b001000 loads `pc` with `rs_val`, with bits [1:0] forced to zero.
- R8: `link_we` is high only for opcode 3 outside reset. `link_addr` is always 31.
- R9: Bits [1:0] of `pc` are always zero.
- R10: Branch arithmetic wraps modulo 2^32. Backward offsets, with bit 15 set, reduce the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 32 | Instruction currently executing |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| pc | output | 32 | Current program counter |
| link_data | output | 32 | Return address (pc + 4) |
| link_addr | output | 5 | Link destination register index (31) |
| link_we | output | 1 | Link write strobe |

## Verification
The hardest cases are the ones whose targets cross limits. One is a branch that wraps past address zero or the top of memory. Another is a region jump made from the last word of a 256 MB region, where `pc + 4` already carries into bit 28. The ports give no direct way to place the counter there. The bench therefore uses register jumps to set `pc` to chosen values near 0, near 0x0FFFFFFC and near 0xFFFFFFFC. From each of those points it sweeps every transfer opcode, a set of extreme offsets, and equal and unequal operand pairs. The expected address is computed arithmetically for each step.

// File: rtl/npc_pkg.sv
// Shared encodings and types for the next-PC unit.
package npc_pkg;
    localparam int XLEN     = 32;
    localparam int OP_W     = 6;
    localparam int IMM_W    = 16;
    localparam int TGT_W    = 26;
    localparam int REGIDX_W = 5;

    localparam logic [OP_W-1:0] OPC_SPECIAL = 6'd0;
    localparam logic [OP_W-1:0] OPC_JUMP    = 6'd2;
    localparam logic [OP_W-1:0] OPC_CALL    = 6'd3;
    localparam logic [OP_W-1:0] OPC_BREQ    = 6'd4;
    localparam logic [OP_W-1:0] OPC_BRNE    = 6'd5;
    localparam logic [5:0]      FN_REGJUMP  = 6'b001000;
    localparam logic [REGIDX_W-1:0] LINK_REG = 5'd31;

    // Next-PC source selection.
    typedef enum logic [2:0] {
        SEL_SEQ,
        SEL_BRANCH,
        SEL_REGION,
        SEL_REG
    } sel_e;

    // Decoded control for one instruction.
    typedef struct packed {
        sel_e sel;
        logic is_breq;
        logic is_brne;
        logic do_link;
    } ctl_t;
endpackage

// File: rtl/npc_decode.sv
// npc_decode: classifies an instruction word into a next-PC source.
// Assumes opcode in [31:26] and funct in [5:0]. Purely combinational.
module npc_decode
    import npc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] instr,
    output ctl_t         ctl
);
    logic [OP_W-1:0] opc;
    logic [5:0]      fn;

    assign opc = instr[W-1 -: OP_W];
    assign fn  = instr[5:0];

    // Map opcode and funct onto a selection and flags.
    always_comb begin
        ctl = '{sel: SEL_SEQ, is_breq: 1'b0, is_brne: 1'b0, do_link: 1'b0};
        unique case (opc)
            OPC_BREQ: begin
                ctl.sel     = SEL_BRANCH;
                ctl.is_breq = 1'b1;
            end
            OPC_BRNE: begin
                ctl.sel     = SEL_BRANCH;
                ctl.is_brne = 1'b1;
            end
            OPC_JUMP: ctl.sel = SEL_REGION;
            OPC_CALL: begin
                ctl.sel     = SEL_REGION;
                ctl.do_link = 1'b1;
            end
            OPC_SPECIAL: if (fn == FN_REGJUMP) ctl.sel = SEL_REG;
            default: ;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
// npc_target: computes the sequential, branch, region and register
// candidate addresses plus the branch condition. Assumes a word-aligned pc.
module npc_target
    import npc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] pc,
    input  logic [W-1:0] instr,
    input  logic [W-1:0] rs_val,
    input  logic [W-1:0] rt_val,
    input  ctl_t         ctl,
    output logic [W-1:0] seq_addr,
    output logic [W-1:0] br_addr,
    output logic [W-1:0] rgn_addr,
    output logic [W-1:0] reg_addr,
    output logic         br_taken
);
    localparam int HI_W = W - TGT_W - 2;

    logic [W-1:0] off_ext;
    logic         ops_equal;

    assign seq_addr = pc + W'(4);

    // Sign-extend the immediate and scale it to bytes.
    always_comb begin
        off_ext  = {{(W-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};
        br_addr  = seq_addr + (off_ext << 2);
        rgn_addr = {seq_addr[W-1 -: HI_W], instr[TGT_W-1:0], 2'b00};
        reg_addr = {rs_val[W-1:2], 2'b00};
    end

    // Evaluate the branch condition.
    always_comb begin
        ops_equal = (rs_val == rt_val);
        br_taken  = (ctl.is_breq & ops_equal) | (ctl.is_brne & ~ops_equal);
    end
endmodule

// File: rtl/npc_unit.sv
// npc_unit: program counter register with next-address selection and
// link output. Synchronous active-low reset clears the pc to 0.
module npc_unit
    import npc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [XLEN-1:0]     instr,
    input  logic [XLEN-1:0]     rs_val,
    input  logic [XLEN-1:0]     rt_val,
    output logic [XLEN-1:0]     pc,
    output logic [XLEN-1:0]     link_data,
    output logic [REGIDX_W-1:0] link_addr,
    output logic                link_we
);
    ctl_t            ctl;
    logic [XLEN-1:0] seq_addr, br_addr, rgn_addr, reg_addr, nxt;
    logic            br_taken;

    npc_decode #(.W(XLEN)) u_dec (.instr(instr), .ctl(ctl));

    npc_target #(.W(XLEN)) u_tgt (
        .pc(pc), .instr(instr), .rs_val(rs_val), .rt_val(rt_val), .ctl(ctl),
        .seq_addr(seq_addr), .br_addr(br_addr), .rgn_addr(rgn_addr),
        .reg_addr(reg_addr), .br_taken(br_taken)
    );

    // Pick the next address from the decoded source.
    always_comb begin
        unique case (ctl.sel)
            SEL_BRANCH: nxt = br_taken ? br_addr : seq_addr;
            SEL_REGION: nxt = rgn_addr;
            SEL_REG:    nxt = reg_addr;
            default:    nxt = seq_addr;
        endcase
    end

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= nxt;
    end

    // Link outputs for the call form.
    assign link_data = seq_addr;
    assign link_addr = LINK_REG;
    assign link_we   = rst_n & ctl.do_link;

    // Assertions next to the guarded logic.
    a_r1_reset_zero: assert property (@(posedge clk) !rst_n |=> pc == '0)
        else $error("R1 reset");
    a_r9_aligned: assert property (@(posedge clk) disable iff (!rst_n) pc[1:0] == 2'b00)
        else $error("R9 alignment");
    a_r2_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:26] inside {6'd1, 6'd6, 6'd7, 6'd8, 6'd35, 6'd43}) |=> pc == $past(pc) + 32'd4)
        else $error("R2 sequential");
    a_r7_regjump: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:26] == 6'd0 && instr[5:0] == 6'b001000) |=> pc == {$past(rs_val[31:2]), 2'b00})
        else $error("R7 register jump");
    a_r6_link_data: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> link_data == pc + 32'd4)
        else $error("R6 link data");
    a_r8_link_only_call: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> instr[31:26] == 6'd3)
        else $error("R8 link strobe");
    a_r5_region_top: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:26] == 6'd2) |=> pc[31:28] == $past(pc[31:28] + {3'b0, &pc[27:2]}))
        else $error("R5 region bits");
endmodule

// File: tb/test_npc_unit.sv
// Self-checking bench for npc_unit: sweeps transfer types from chosen start points.
module test_npc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = 32'd0, rs_val = 32'd0, rt_val = 32'd0;
    logic [31:0] pc, link_data;
    logic [4:0]  link_addr;
    logic        link_we;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    npc_unit i_npc_unit (
        .clk(clk), .rst_n(rst_n), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
        .pc(pc), .link_data(link_data), .link_addr(link_addr), .link_we(link_we)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one instruction, clock once, sample after the edge.
    task automatic step(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b);
        instr = i; rs_val = a; rt_val = b;
        @(posedge clk); #1;
    endtask

    task automatic set_pc(input logic [31:0] v);
        step({6'd0, 20'd0, 6'b001000}, v, 32'd0);
        chk("R7", pc, {v[31:2], 2'b00});
    endtask

    function automatic logic [31:0] brt(input logic [31:0] p, input logic [15:0] o);
        return p + 32'd4 + ({{16{o[15]}}, o} * 32'd4);
    endfunction

    initial begin
        logic [31:0] starts [4];
        logic [15:0] offs [5];
        logic [31:0] p;
        starts = '{32'h0, 32'h0FFF_FFFC, 32'hFFFF_FFFC, 32'h7000_0010};
        offs   = '{16'd25, 16'hFFFF, 16'h8000, 16'h7FFF, 16'd0};
        step(32'h1234_5678, 32'd0, 32'd0);
        chk("R1", pc, 32'd0);
        chk("R1", {31'd0, link_we}, 32'd0);
        rst_n = 1'b1;
        step(32'h2000_0000, 32'd0, 32'd0);
        chk("R2", pc, 32'd4);
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 5; k++) begin
                set_pc(starts[s]); p = pc;
                step({6'd4, 10'd0, offs[k]}, 32'd9, 32'd9);
                chk("R3 taken R10", pc, brt(p, offs[k]));
                set_pc(starts[s]); p = pc;
                step({6'd4, 10'd0, offs[k]}, 32'd9, 32'd8);
                chk("R3 not taken", pc, p + 32'd4);
                set_pc(starts[s]); p = pc;
                step({6'd5, 10'd0, offs[k]}, 32'd1, 32'd2);
                chk("R4 taken R10", pc, brt(p, offs[k]));
                set_pc(starts[s]); p = pc;
                step({6'd5, 10'd0, offs[k]}, 32'd7, 32'd7);
                chk("R4 not taken", pc, p + 32'd4);
            end
            set_pc(starts[s]); p = pc;
            step({6'd2, 26'h3FF_FFFF}, 32'd0, 32'd0);
            chk("R5", pc, {p[31:28] + {3'd0, &p[27:2]}, 28'hFFF_FFFC});
            set_pc(starts[s]); p = pc;
            instr = {6'd3, 26'h000_1234}; #1;
            chk("R6 strobe", {31'd0, link_we}, 32'd1);
            chk("R6 data", link_data, p + 32'd4);
            chk("R8 addr", {27'd0, link_addr}, 32'd31);
            @(posedge clk); #1;
            chk("R6 target", pc, {(p + 32'd4) & 32'hF000_0000} | 32'h0000_48D0);
            for (int op = 6; op < 64; op += 7) begin
                p = pc;
                step({op[5:0], 26'h155_5555}, 32'd3, 32'd3);
                chk("R2 other opcode", pc, p + 32'd4);
                chk("R8 no link", {31'd0, link_we}, 32'd0);
            end
            p = pc;
            step({6'd0, 20'd0, 6'b001001}, 32'h8000_0000, 32'd0);
            chk("R2 other funct", pc, p + 32'd4);
        end
        step({6'd0, 20'd0, 6'b001000}, 32'h1234_5677, 32'd0);
        chk("R7 R9 low bits", pc, 32'h1234_5674);
        instr = {6'd3, 26'd0}; rst_n = 1'b0; #1;
        chk("R1 no link in reset", {31'd0, link_we}, 32'd0);
        @(posedge clk); #1;
        chk("R1 reset mid-run", pc, 32'd0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule